// File: doc/BRIEF.md
# Atomic Counter Unit

A shared space of 2048 bytes of counters that many requesters update through one serialized port. Every operation is an indivisible read-modify-write on a lane of 8, 16, 32 or 64 bits. A lane is picked by a byte offset, and bytes are numbered big-endian inside each 64-bit counter word. A requester that numbers bytes little-endian reaches the same lane by XOR-ing the offset with 7, 6 or 4 for 8-, 16- and 32-bit lanes.

Three command kinds exist. A load-style command adds a signed 22-bit increment and returns the old value on the response port. A store-style command adds its data word to the lane or overwrites the lane with it, and returns nothing. An asynchronous command adds like a load, but its old value leaves on a scratchpad write port aimed at a word address taken from the command. Load and asynchronous commands can ask to wait for an external tag switch to finish. A wait that lasts too long ends with an error flag, and the counter is left untouched.

Top module: `atomic_counter_unit`

## Requirements
- R1: After reset every counter reads zero, `cmd_ready` is high, and neither `rsp_valid` nor `scr_valid` is asserted.
- R2: Only one command is in flight at a time, and `cmd_ready` is low from the accepting edge until it completes. A command that does not wait puts its result out one cycle after the accepting edge, as a one-cycle pulse.
- R3: `cmd_kind` 0 is a load, 1 a store and 2 asynchronous; 3 acts as a load. The lane size sits in `cmd_word[12:11]` (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits) and the byte offset in `cmd_word[10:0]`.
- R4: A load or asynchronous command returns the lane's value from before the update, sign-extended to 64 bits. The lane becomes old plus increment, wrapping modulo the lane width with no saturation.
- R5: The increment of a load or asynchronous command is `cmd_word[35:14]`, read as a signed 22-bit value and sign-extended before the add.
- R6: In a store, `cmd_word[13]` = 0 adds the low lane bits of `cmd_wdata` to the lane, and `cmd_word[13]` = 1 overwrites the lane with them. A store produces no response on either port.
- R7: Byte offset 0 of a counter word is bits 63:56 of that word. A lane of N bytes at aligned offset k holds bytes k to k+N-1, with byte k most significant.
- R8: Offset bits below the lane alignment are ignored: 2-byte lanes clear bit 0, 4-byte lanes clear bits 1:0 and 8-byte lanes clear bits 2:0.
- R9: An asynchronous command delivers its result on `scr_valid`/`scr_data` at scratchpad word `cmd_word[63:56]`, and never on the response port.
- R10: When `cmd_word[13]` is set on a load or asynchronous command, the update waits while `tag_switch_pending` is high. Once it is sampled low, the update runs and the result appears two cycles later. The result has bit 63 clear and the old value in bits 62:0.
- R11: If `tag_switch_pending` stays high for `TIMEOUT_CYCLES` cycles after acceptance, the result is {1, 63 zeros}. It appears `TIMEOUT_CYCLES` edges after the accepting edge, and the counter is unchanged.
- R12: Commands run in acceptance order, and each one sees every earlier update to the same lane.
- R13: An update changes no byte outside its addressed lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle and able to take a command |
| cmd_kind | input | 2 | 0 load, 1 store, 2 asynchronous, 3 treated as load |
| cmd_word | input | 64 | Command fields: scratch word, increment, flag, size, offset |
| cmd_wdata | input | 64 | Store data, used by store commands only |
| tag_switch_pending | input | 1 | High while an external tag switch is unfinished |
| rsp_valid | output | 1 | Load result pulse |
| rsp_data | output | 64 | Load result |
| scr_valid | output | 1 | Scratchpad write pulse for asynchronous results |
| scr_addr | output | 8 | Scratchpad word address |
| scr_data | output | 64 | Asynchronous result |

## Verification
The bench goes after lane placement inside a word. A byte-order or shift error would show up as the wrong byte from an 8-bit read of a known 64-bit pattern, or as a changed neighbour byte after a narrow add. It checks wrap at the sign boundary and the negative 22-bit increment, where a missing sign extension would return 0x80 instead of a negative value or add 2^22-1. Misaligned offsets are covered, and a design that does not mask them would address the wrong bytes. Tag-wait is checked for an early result while the switch is still pending, for the exact timeout latency, and for a counter that a timed-out command left unchanged, where a faulty timer would still apply the add.

// File: rtl/acu_pkg.sv
// Shared types for the atomic counter unit: command kinds, lane sizes,
// controller states and the decoded command record.
package acu_pkg;
    parameter int ACU_DW    = 64;  // counter word width
    parameter int ACU_OFF_W = 11;  // byte offset field width
    parameter int ACU_SCR_W = 8;   // scratchpad word address width

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_ASYNC = 2'd2
    } acu_kind_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } acu_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2
    } acu_state_e;

    typedef struct packed {
        acu_kind_e             kind;
        logic                  overwrite;
        logic                  tagwait;
        acu_size_e             size;
        logic [ACU_OFF_W-1:0]  offset;
        logic [ACU_DW-1:0]     operand;
        logic [ACU_SCR_W-1:0]  scr_addr;
    } acu_cmd_t;
endpackage

// File: rtl/acu_decode.sv
// Splits a raw command word into a decoded record.
// Assumes the caller only samples the result on an accepted command.
module acu_decode
    import acu_pkg::*;
#(
    parameter int INC_W   = 22,
    parameter int INC_LSB = 14
) (
    input  logic [1:0]        kind_i,
    input  logic [ACU_DW-1:0] word_i,
    input  logic [ACU_DW-1:0] wdata_i,
    output acu_cmd_t          cmd_o
);
    localparam int INC_MSB = INC_LSB + INC_W - 1;

    logic is_store;
    logic unused_len;

    assign is_store   = (kind_i == 2'd1);
    assign unused_len = ^word_i[55:INC_MSB+1];

    // Field extraction and increment sign extension
    always_comb begin
        cmd_o.kind      = is_store ? KIND_STORE :
                          (kind_i == 2'd2) ? KIND_ASYNC : KIND_LOAD;
        cmd_o.overwrite = is_store & word_i[13];
        cmd_o.tagwait   = ~is_store & word_i[13];
        cmd_o.size      = acu_size_e'(word_i[12:11]);
        cmd_o.offset    = word_i[ACU_OFF_W-1:0];
        cmd_o.scr_addr  = word_i[ACU_DW-1 -: ACU_SCR_W];
        cmd_o.operand   = is_store ? wdata_i :
                          {{(ACU_DW-INC_W){word_i[INC_MSB]}}, word_i[INC_MSB:INC_LSB]};
    end
endmodule

// File: rtl/acu_lane_alu.sv
// Picks a big-endian lane out of a counter word, sign-extends the old value,
// computes add or overwrite, and merges the new lane back into the word.
// Assumes the offset bits below the lane alignment carry no meaning.
module acu_lane_alu
    import acu_pkg::*;
(
    input  logic [ACU_DW-1:0] word_i,
    input  acu_size_e         size_i,
    input  logic [2:0]        byte_off_i,
    input  logic [ACU_DW-1:0] operand_i,
    input  logic              overwrite_i,
    output logic [ACU_DW-1:0] old_o,
    output logic [ACU_DW-1:0] word_o
);
    logic [3:0]        nbytes;
    logic [2:0]        base;
    logic [6:0]        shamt;
    logic [ACU_DW-1:0] mask;
    logic [ACU_DW-1:0] lane;
    logic [ACU_DW-1:0] upd;

    // Lane position, extraction, update and merge
    always_comb begin
        nbytes = 4'd1 << size_i;
        base   = byte_off_i & ~(nbytes[2:0] - 3'd1);
        shamt  = {(4'd8 - {1'b0, base} - nbytes), 3'b000};
        mask   = (size_i == SZ_64) ? '1 :
                 ((ACU_DW'(1) << {nbytes, 3'b000}) - ACU_DW'(1));
        lane   = (word_i >> shamt) & mask;
        case (size_i)
            SZ_8:    old_o = {{(ACU_DW-8){lane[7]}},   lane[7:0]};
            SZ_16:   old_o = {{(ACU_DW-16){lane[15]}}, lane[15:0]};
            SZ_32:   old_o = {{(ACU_DW-32){lane[31]}}, lane[31:0]};
            default: old_o = lane;
        endcase
        upd    = (overwrite_i ? operand_i : (lane + operand_i)) & mask;
        word_o = (word_i & ~(mask << shamt)) | (upd << shamt);
    end
endmodule

// File: rtl/acu_counter_mem.sv
// Flop-based counter storage: one combinational read port and one
// synchronous write port. Every word clears to zero on reset.
module acu_counter_mem
    import acu_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ACU_DW-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ACU_DW-1:0] wr_data
);
    logic [WORDS-1:0][ACU_DW-1:0] cells;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [ACU_DW-1:0] q;
        // Hold one counter word and load it when it is addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(w)))
                q <= wr_data;
        end
        assign cells[w] = q;
    end

    assign rd_data = cells[rd_idx];
endmodule

// File: rtl/acu_wait_timer.sv
// Counts cycles spent waiting on a pending tag switch and flags expiry.
// Assumes start_i pulses on acceptance and active_i is high only while waiting.
module acu_wait_timer #(
    parameter int TIMEOUT = 64,
    localparam int CW = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic active_i,
    input  logic pending_i,
    output logic expire_o
);
    logic [CW-1:0] cnt;

    assign expire_o = active_i && pending_i && (cnt == CW'(TIMEOUT - 1));

    // Restart on acceptance, advance on each pending wait cycle
    always_ff @(posedge clk) begin
        if (!rst_n || start_i)
            cnt <= '0;
        else if (active_i && pending_i && !expire_o)
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/atomic_counter_unit.sv
// Serialized atomic counter unit. Takes one command at a time, optionally
// waits for a tag switch, performs the read-modify-write in one cycle and
// returns the old value on the response or scratchpad port.
// Assumes the requester holds cmd_* stable while cmd_valid is high.
module atomic_counter_unit
    import acu_pkg::*;
#(
    parameter int SPACE_BYTES    = 2048,
    parameter int INC_W          = 22,
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [1:0]           cmd_kind,
    input  logic [ACU_DW-1:0]    cmd_word,
    input  logic [ACU_DW-1:0]    cmd_wdata,
    input  logic                 tag_switch_pending,
    output logic                 rsp_valid,
    output logic [ACU_DW-1:0]    rsp_data,
    output logic                 scr_valid,
    output logic [ACU_SCR_W-1:0] scr_addr,
    output logic [ACU_DW-1:0]    scr_data
);
    localparam int WORDS = SPACE_BYTES / 8;
    localparam int IDX_W = $clog2(WORDS);

    acu_state_e        state;
    acu_cmd_t          dec_cmd;
    acu_cmd_t          cur;
    logic              accept;
    logic              expire;
    logic              mem_we;
    logic [IDX_W-1:0]  word_idx;
    logic [ACU_DW-1:0] rd_word;
    logic [ACU_DW-1:0] new_word;
    logic [ACU_DW-1:0] old_val;
    logic              fin_valid;
    logic [ACU_DW-1:0] fin_val;

    assign cmd_ready = (state == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign mem_we    = (state == ST_EXEC);
    assign word_idx  = cur.offset[3 +: IDX_W];

    acu_decode #(.INC_W(INC_W)) u_dec (
        .kind_i  (cmd_kind),
        .word_i  (cmd_word),
        .wdata_i (cmd_wdata),
        .cmd_o   (dec_cmd)
    );

    acu_counter_mem #(.WORDS(WORDS)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (word_idx),
        .rd_data (rd_word),
        .wr_en   (mem_we),
        .wr_idx  (word_idx),
        .wr_data (new_word)
    );

    acu_lane_alu u_alu (
        .word_i      (rd_word),
        .size_i      (cur.size),
        .byte_off_i  (cur.offset[2:0]),
        .operand_i   (cur.operand),
        .overwrite_i (cur.overwrite),
        .old_o       (old_val),
        .word_o      (new_word)
    );

    acu_wait_timer #(.TIMEOUT(TIMEOUT_CYCLES)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (accept),
        .active_i  (state == ST_WAIT),
        .pending_i (tag_switch_pending),
        .expire_o  (expire)
    );

    // Pick the value to deliver: old value, flagged old value or timeout word
    always_comb begin
        fin_valid = 1'b0;
        fin_val   = '0;
        if (state == ST_EXEC && cur.kind != KIND_STORE) begin
            fin_valid = 1'b1;
            fin_val   = cur.tagwait ? {1'b0, old_val[ACU_DW-2:0]} : old_val;
        end else if (state == ST_WAIT && expire) begin
            fin_valid = 1'b1;
            fin_val   = {1'b1, {(ACU_DW-1){1'b0}}};
        end
    end

    // Command sequencing: accept, optional wait, execute
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    cur   <= dec_cmd;
                    state <= dec_cmd.tagwait ? ST_WAIT : ST_EXEC;
                end
                ST_WAIT: begin
                    if (!tag_switch_pending) state <= ST_EXEC;
                    else if (expire)         state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Result registers for the response and scratchpad ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            scr_valid <= 1'b0;
            scr_addr  <= '0;
            scr_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            scr_valid <= 1'b0;
            if (fin_valid) begin
                if (cur.kind == KIND_ASYNC) begin
                    scr_valid <= 1'b1;
                    scr_addr  <= cur.scr_addr;
                    scr_data  <= fin_val;
                end else begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= fin_val;
                end
            end
        end
    end
endmodule

// File: rtl/acu_checker.sv
// Protocol checks for the atomic counter unit, attached by bind.
module acu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [1:0]  cmd_kind,
    input logic [63:0] cmd_word,
    input logic        rsp_valid,
    input logic        scr_valid,
    input logic [7:0]  scr_addr
);
    logic acc;
    assign acc = cmd_valid && cmd_ready;

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !cmd_ready); // R2
    AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (cmd_kind == 2'd0 || cmd_kind == 2'd3) && !cmd_word[13]) |-> ##2 rsp_valid); // R2
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R2
    AST_STORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_kind == 2'd1) |-> ##2 (!rsp_valid && !scr_valid)); // R6
    AST_ASYNC_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_kind == 2'd2 && !cmd_word[13]) |-> ##2
        (scr_valid && !rsp_valid && scr_addr == $past(cmd_word[63:56], 2))); // R9
    AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && scr_valid)); // R9
endmodule

bind atomic_counter_unit acu_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_kind  (cmd_kind),
    .cmd_word  (cmd_word),
    .rsp_valid (rsp_valid),
    .scr_valid (scr_valid),
    .scr_addr  (scr_addr)
);

// File: tb/atomic_counter_unit_test.sv
`timescale 1ns/1ps
module atomic_counter_unit_test;
    localparam int TMO = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_kind = '0;
    logic [63:0] cmd_word = '0;
    logic [63:0] cmd_wdata = '0;
    logic        tag_pend = 1'b0;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        scr_valid;
    logic [7:0]  scr_addr;
    logic [63:0] scr_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] refm [0:2047];

    always #2.5 clk = ~clk;

    atomic_counter_unit #(.TIMEOUT_CYCLES(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_word(cmd_word), .cmd_wdata(cmd_wdata),
        .tag_switch_pending(tag_pend), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .scr_valid(scr_valid), .scr_addr(scr_addr), .scr_data(scr_data)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] sext(input logic [63:0] v, input int nb);
        case (nb)
            1:       return {{56{v[7]}}, v[7:0]};
            2:       return {{48{v[15]}}, v[15:0]};
            4:       return {{32{v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

    // Big-endian lane read from the reference byte array (R7)
    function automatic logic [63:0] ref_get(input int a, input int nb);
        logic [63:0] v = '0;
        for (int i = 0; i < nb; i++) v = (v << 8) | 64'(refm[a+i]);
        return sext(v, nb);
    endfunction

    task automatic ref_put(input int a, input int nb, input logic [63:0] v);
        for (int i = 0; i < nb; i++) refm[a+i] = v[8*(nb-1-i) +: 8];
    endtask

    // Issue one command, wait for its result and compare with the model
    task automatic run_op(input int kind, input int sz, input int off,
                          input logic [63:0] val, input bit flag,
                          input logic [7:0] scr, input int release_at,
                          input string req);
        int nb = 1 << sz;
        int a = off & ~(nb - 1);
        int lat = 0;
        bit is_store = (kind == 1);
        bit waits = flag && !is_store;
        bit tmo = waits && (release_at < 0);
        logic [63:0] old = ref_get(a, nb);
        logic [63:0] nv;
        logic [63:0] exp;
        bit saw_r = 0;
        bit saw_s = 0;
        logic [63:0] got = '0;
        if (is_store) nv = flag ? val : old + val;
        else          nv = old + {{42{val[21]}}, val[21:0]};
        exp = tmo ? 64'h8000_0000_0000_0000 :
              waits ? {1'b0, old[62:0]} : old;
        @(negedge clk);
        check(cmd_ready, "R2", 64'(cmd_ready), 64'd1);
        cmd_valid = 1'b1;
        cmd_kind  = 2'(kind);
        cmd_word  = {scr, 8'd1, 12'd0, val[21:0], flag, 2'(sz), 11'(off)};
        cmd_wdata = val;
        tag_pend  = waits;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        while (1'b1) begin
            if (rsp_valid) begin saw_r = 1; got = rsp_data; end
            if (scr_valid) begin saw_s = 1; got = scr_data; end
            if (saw_r || saw_s) break;
            if (is_store && lat >= 4) break;
            if (lat > TMO + 8) break;
            if (lat == release_at) tag_pend = 1'b0;
            @(negedge clk);
            lat++;
        end
        tag_pend = 1'b0;
        if (is_store) begin
            check(!saw_r && !saw_s, "R6", 64'(saw_r | saw_s), 64'd0);
        end else begin
            if (kind == 2) begin
                check(saw_s && !saw_r, "R9", 64'(saw_s), 64'd1);
                check(scr_addr == scr, "R9", 64'(scr_addr), 64'(scr));
            end else begin
                check(saw_r && !saw_s, "R3", 64'(saw_r), 64'd1);
            end
            check(got == exp, req, got, exp);
            if (tmo)        check(lat == TMO + 1, "R11", 64'(lat), 64'(TMO + 1));
            else if (waits) check(lat == release_at + 2, "R10", 64'(lat), 64'(release_at + 2));
            else            check(lat == 2, "R2", 64'(lat), 64'd2);
        end
        if (!tmo) ref_put(a, nb, nv);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2048; i++) refm[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R1", 64'(cmd_ready), 64'd1);
        check(!rsp_valid && !scr_valid, "R1", 64'(rsp_valid | scr_valid), 64'd0);
        run_op(0, 3, 12'h100, 64'd0, 0, 8'h00, -1, "R1");
        // R12: back-to-back adds on one counter see each other's results
        for (int k = 0; k < 3; k++) run_op(0, 2, 12'h40, 64'd3, 0, 8'h00, -1, "R12");
        // R5: negative 22-bit increment
        run_op(0, 3, 12'h48, 64'h3F_FFFF, 0, 8'h00, -1, "R5");
        run_op(0, 3, 12'h48, 64'd0, 0, 8'h00, -1, "R5");
        // R4: wrap at the 8-bit sign boundary
        run_op(1, 0, 12'h50, 64'h7F, 1, 8'h00, -1, "R6");
        run_op(0, 0, 12'h50, 64'd1, 0, 8'h00, -1, "R4");
        run_op(0, 0, 12'h50, 64'd0, 0, 8'h00, -1, "R4");
        // R7 and R13: big-endian lanes, neighbours untouched
        run_op(1, 3, 12'h58, 64'h1122_3344_5566_7788, 1, 8'h00, -1, "R6");
        run_op(0, 0, 12'h5B, 64'd1, 0, 8'h00, -1, "R7");
        run_op(0, 3, 12'h58, 64'd0, 0, 8'h00, -1, "R13");
        run_op(0, 0, 12'h58, 64'd0, 0, 8'h00, -1, "R7");
        run_op(0, 1, 12'h5E, 64'd0, 0, 8'h00, -1, "R7");
        run_op(0, 2, 12'h5C, 64'd0, 0, 8'h00, -1, "R7");
        // R8: misaligned offsets fold onto the aligned lane
        run_op(0, 2, 12'h5F, 64'd0, 0, 8'h00, -1, "R8");
        run_op(0, 1, 12'h5F, 64'd0, 0, 8'h00, -1, "R8");
        run_op(0, 3, 12'h5D, 64'd0, 0, 8'h00, -1, "R8");
        // R6: store-add on a 16-bit lane
        run_op(1, 1, 12'h5E, 64'h0011, 0, 8'h00, -1, "R6");
        run_op(0, 1, 12'h5E, 64'd0, 0, 8'h00, -1, "R6");
        // R10: tag-wait with release, top bit of the old value dropped
        run_op(1, 3, 12'h60, 64'h8000_0000_0000_0005, 1, 8'h00, -1, "R6");
        run_op(0, 3, 12'h60, 64'd2, 1, 8'h00, 4, "R10");
        // R11: timeout on load and async, counter left unchanged
        run_op(0, 3, 12'h60, 64'd9, 1, 8'h00, -1, "R11");
        run_op(2, 2, 12'h60, 64'd9, 1, 8'h33, -1, "R11");
        run_op(0, 3, 12'h60, 64'd0, 0, 8'h00, -1, "R11");
        // R9: asynchronous result to the scratchpad port
        run_op(2, 2, 12'h40, 64'd1, 0, 8'hA5, -1, "R9");
        // R3: kind code 3 behaves as a load
        run_op(3, 2, 12'h40, 64'd0, 0, 8'h00, -1, "R3");
        // Random mix over a small region so commands collide
        for (int n = 0; n < 300; n++) begin
            int kd = int'($urandom % 4);
            int sz = int'($urandom % 4);
            int of = int'($urandom % 48);
            logic [63:0] v = {$urandom, $urandom};
            bit fl = (kd == 1) ? bit'($urandom % 2) : ($urandom % 4 == 0);
            int rel = 1 + int'($urandom % 5);
            string rq = (kd == 1) ? "R6" : (kd == 2) ? "R9" : "R4";
            run_op(kd, sz, of, v, fl, 8'($urandom), rel, rq);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule